// File: doc/BRIEF.md
# Wait-State Register Write Target for an APB Bus

This block is a small peripheral on an APB (revision 3/4 style) bus. It holds a bank of 32-bit registers. Before it signals completion of any transfer it holds the bus for a number of cycles taken from a wait-count input. A write lands in the addressed register only on the clock edge that completes the transfer, and only in the byte lanes whose strobe bit is set. A word address outside the bank, or a misaligned address, finishes normally but raises the error response and changes no register. A plain readback path returns register contents in the completing cycle.

The wait count is captured in the setup cycle of each transfer. The internal counter restarts whenever select is high and enable is low. This lets consecutive transfers that keep select asserted each receive the full wait. A wait count of zero gives the minimum two-cycle transfer.

Top module: `apb_wait_regbank`

## Requirements
- R1: After reset every register reads back as 0x00000000, and ready and error are low while no transfer is in its access phase.
- R2: With a wait count of W sampled in the setup cycle, ready stays low for exactly W access cycles and rises in access cycle W+1, so the access phase lasts W+1 cycles.
- R3: A register changes only on the rising edge where select, enable, ready and write are all high. A read transfer carrying arbitrary write data and strobes leaves the register unchanged.
- R4: Ready is driven low in every cycle where enable is low, including every setup cycle.
- R5: Select high with enable low reloads the wait counter. A transfer that directly follows another with select held high receives its full W wait states again.
- R6: The error output is high only together with ready. It is high for an address with word index at or beyond the register count. A write to such an address changes no register.
- R7: With a wait count of zero, ready is high in the first access cycle, so the transfer takes two cycles in total.
- R8: Strobe bit k enables byte lane k (data bits 8k+7 down to 8k) of the addressed register. Lanes whose strobe bit is low keep their previous value, and an all-zero strobe changes nothing.
- R9: Registers sit at byte address 4*i for index i. An address whose two low bits are not zero is unmapped (R6 applies). Read data carries the addressed register in the completing cycle of a mapped read and is zero in every other cycle.
- R10: A change of the wait-count input after the setup cycle has no effect on the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Peripheral select |
| enable_i | input | 1 | Access-phase enable |
| addr_i | input | ADDR_W | Byte address |
| write_i | input | 1 | 1 = write transfer, 0 = read transfer |
| wdata_i | input | DATA_W | Write data |
| strb_i | input | DATA_W/8 | Byte-lane write strobes |
| wait_cycles_i | input | WAIT_W | Number of wait states for transfers that start now |
| ready_o | output | 1 | Transfer completes in this cycle |
| err_o | output | 1 | Error response, valid with ready |
| rdata_o | output | DATA_W | Read data, valid with ready on a read |

## Verification
The bench builds the block with four registers and a 3-bit wait count, 12-bit addresses and 32-bit data. With only four registers, byte address 0x10 already falls outside the bank, so the unmapped-address error and its no-write guarantee can be reached with small addresses. The 3-bit wait count lets the bench try the full span from zero up to the maximum of seven waits. That covers the two-cycle minimum, the longest stall, and a change of the count in the middle of a transfer. All transfers in the vector table run back to back with select held high, so every one of them also exercises the counter reload in the setup cycle.

// File: rtl/apb_wait_regbank_pkg.sv
package apb_wait_regbank_pkg;

  // Bus phase as seen by the completer, decoded from select and enable.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } bus_phase_e;

  localparam int unsigned LANE_W = 8;

  function automatic bus_phase_e decode_phase(input logic sel, input logic en);
    if (!sel)     return PH_IDLE;
    else if (!en) return PH_SETUP;
    else          return PH_ACCESS;
  endfunction

endpackage

// File: rtl/apb_wait_timer.sv
// Wait-state counter: loaded in each setup cycle, counts down in access.
module apb_wait_timer #(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_i,
  input  logic              access_i,
  input  logic [WAIT_W-1:0] load_i,
  output logic              expired_o
);

  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] cnt_d;
  logic              cnt_en;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (setup_i) begin
      // Every setup cycle restarts the count, even between
      // back-to-back transfers that keep select high.
      cnt_en = 1'b1;
      cnt_d  = load_i;
    end else if (access_i && !at_zero) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = access_i && at_zero;

endmodule

// File: rtl/apb_addr_decode.sv
// Maps a byte address to a register index and a hit flag.
module apb_addr_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic [ADDR_W-1:0]           addr_i,
  output logic                        hit_o,
  output logic [$clog2(NUM_REGS)-1:0] idx_o
);

  localparam int unsigned IDX_W  = $clog2(NUM_REGS);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NUM_REGS);

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign hit_o   = aligned && (word < LIMIT);
  assign idx_o   = word[IDX_W-1:0];

endmodule

// File: rtl/apb_reg_store.sv
// Register bank with per-byte-lane write enables and a read mux.
module apb_reg_store
  import apb_wait_regbank_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit_i,
  input  logic [$clog2(NUM_REGS)-1:0] idx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [DATA_W/LANE_W-1:0]    strb_i,
  output logic [DATA_W-1:0]           rd_o
);

  localparam int unsigned IDX_W   = $clog2(NUM_REGS);
  localparam int unsigned LANES   = DATA_W / LANE_W;

  logic [NUM_REGS-1:0][DATA_W-1:0] contents;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic row_sel;
    assign row_sel = commit_i && (idx_i == IDX_W'(r));

    for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [LANE_W-1:0] byte_q;
      logic [LANE_W-1:0] byte_d;
      logic              byte_en;

      assign byte_en = row_sel && strb_i[b];
      assign byte_d  = wdata_i[b*LANE_W +: LANE_W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byte_q <= '0;
        end else if (byte_en) begin
          byte_q <= byte_d;
        end
      end

      assign contents[r][b*LANE_W +: LANE_W] = byte_q;
    end
  end

  always_comb begin
    rd_o = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (idx_i == IDX_W'(r)) rd_o = contents[r];
    end
  end

endmodule

// File: rtl/apb_wait_regbank.sv
// APB completer: register bank with programmable wait states.
module apb_wait_regbank
  import apb_wait_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned WAIT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_i,
  input  logic                     enable_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     write_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W/LANE_W-1:0] strb_i,
  input  logic [WAIT_W-1:0]        wait_cycles_i,
  output logic                     ready_o,
  output logic                     err_o,
  output logic [DATA_W-1:0]        rdata_o
);

  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  bus_phase_e        phase;
  logic              in_setup;
  logic              in_access;
  logic              expired;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              commit;
  logic [DATA_W-1:0] rd_word;

  assign phase     = decode_phase(sel_i, enable_i);
  assign in_setup  = (phase == PH_SETUP);
  assign in_access = (phase == PH_ACCESS);

  apb_wait_timer #(
    .WAIT_W (WAIT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .setup_i   (in_setup),
    .access_i  (in_access),
    .load_i    (wait_cycles_i),
    .expired_o (expired)
  );

  apb_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_decode (
    .addr_i (addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  // Write lands only in the completing cycle of a mapped write.
  assign commit = expired && write_i && hit;

  apb_reg_store #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .idx_i    (idx),
    .wdata_i  (wdata_i),
    .strb_i   (strb_i),
    .rd_o     (rd_word)
  );

  assign ready_o = expired;
  assign err_o   = expired && !hit;
  assign rdata_o = (expired && hit && !write_i) ? rd_word : '0;

endmodule

// File: rtl/apb_wait_regbank_chk.sv
// Protocol checker attached to the completer.
module apb_wait_regbank_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WAIT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic              enable_i,
  input logic [WAIT_W-1:0] wait_cycles_i,
  input logic              ready_o,
  input logic              err_o,
  input logic [DATA_W-1:0] rdata_o
);

  // R4: no completion outside the access phase
  a_r4_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> !ready_o);

  // R6: error only accompanies ready
  a_r6_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ready_o);

  // R7: zero wait count gives completion in the first access cycle
  a_r7_zero_wait_first_access: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && enable_i && $past(sel_i && !enable_i) && ($past(wait_cycles_i) == '0))
      |-> ready_o);

  // R5: a fresh setup with nonzero count forces a wait in the first access cycle
  a_r5_setup_restarts_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && enable_i && $past(sel_i && !enable_i) && ($past(wait_cycles_i) != '0))
      |-> !ready_o);

  // R9: read data is zero outside completing cycles
  a_r9_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (rdata_o == '0));

endmodule

bind apb_wait_regbank apb_wait_regbank_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WAIT_W (WAIT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sel_i         (sel_i),
  .enable_i      (enable_i),
  .wait_cycles_i (wait_cycles_i),
  .ready_o       (ready_o),
  .err_o         (err_o),
  .rdata_o       (rdata_o)
);

// File: tb/test_apb_wait_regbank.sv
module test_apb_wait_regbank;

  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned WAIT_W   = 3;

  logic              clk;
  logic              rst_n;
  logic              sel_i;
  logic              enable_i;
  logic [ADDR_W-1:0] addr_i;
  logic              write_i;
  logic [DATA_W-1:0] wdata_i;
  logic [3:0]        strb_i;
  logic [WAIT_W-1:0] wait_cycles_i;
  logic              ready_o;
  logic              err_o;
  logic [DATA_W-1:0] rdata_o;

  int n_checks = 0;
  int n_fails  = 0;

  apb_wait_regbank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .WAIT_W   (WAIT_W)
  ) i_apb_wait_regbank (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_i         (sel_i),
    .enable_i      (enable_i),
    .addr_i        (addr_i),
    .write_i       (write_i),
    .wdata_i       (wdata_i),
    .strb_i        (strb_i),
    .wait_cycles_i (wait_cycles_i),
    .ready_o       (ready_o),
    .err_o         (err_o),
    .rdata_o       (rdata_o)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [3:0]  strb;
    logic [2:0]  wt;
    logic        err;
    logic [31:0] rdata;
  } vec_t;

  // Expected values worked out from R6, R8 and R9 by hand.
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h000, 32'h11223344, 4'hF, 3'd0, 1'b0, 32'h0},
    '{1'b0, 12'h000, 32'h0,        4'h0, 3'd2, 1'b0, 32'h11223344},
    '{1'b1, 12'h004, 32'hA5A5A5A5, 4'h5, 3'd3, 1'b0, 32'h0},
    '{1'b0, 12'h004, 32'hFFFFFFFF, 4'hF, 3'd1, 1'b0, 32'h00A500A5},
    '{1'b1, 12'h008, 32'hDEADBEEF, 4'hA, 3'd7, 1'b0, 32'h0},
    '{1'b0, 12'h008, 32'h0,        4'h0, 3'd0, 1'b0, 32'hDE00BE00},
    '{1'b1, 12'h010, 32'hFFFFFFFF, 4'hF, 3'd2, 1'b1, 32'h0},
    '{1'b0, 12'h010, 32'h0,        4'h0, 3'd1, 1'b1, 32'h0},
    '{1'b1, 12'h002, 32'h55555555, 4'hF, 3'd0, 1'b1, 32'h0},
    '{1'b0, 12'h000, 32'h0,        4'h0, 3'd0, 1'b0, 32'h11223344},
    '{1'b1, 12'h00C, 32'hFFFFFFFF, 4'h0, 3'd1, 1'b0, 32'h0},
    '{1'b0, 12'h00C, 32'h0,        4'h0, 3'd4, 1'b0, 32'h00000000},
    '{1'b1, 12'h000, 32'hCAFEF00D, 4'h3, 3'd5, 1'b0, 32'h0},
    '{1'b0, 12'h000, 32'h0,        4'h0, 3'd6, 1'b0, 32'h1122F00D}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  task automatic go_idle();
    @(negedge clk);
    sel_i    = 1'b0;
    enable_i = 1'b0;
  endtask

  // One transfer; the wait count is applied in setup (ws) and changed to wa in access.
  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] s, input logic [2:0] ws, input logic [2:0] wa,
                      output int cyc, output logic e, output logic [31:0] rd);
    @(negedge clk);
    sel_i = 1'b1; enable_i = 1'b0; addr_i = a; write_i = wr;
    wdata_i = d; strb_i = s; wait_cycles_i = ws;
    #1;
    check("R4 ready low in setup", 32'(ready_o), 32'd0);
    check("R9 rdata zero in setup", rdata_o, 32'd0);
    @(negedge clk);
    enable_i = 1'b1;
    wait_cycles_i = wa;
    cyc = 1;
    #1;
    while (!ready_o && cyc < 40) begin
      check("R6 err low while waiting", 32'(err_o), 32'd0);
      @(negedge clk);
      cyc++;
      #1;
    end
    e  = err_o;
    rd = rdata_o;
  endtask

  initial begin
    int cyc;
    logic e;
    logic [31:0] rd;
    sel_i = 0; enable_i = 0; addr_i = '0; write_i = 0;
    wdata_i = '0; strb_i = '0; wait_cycles_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 ready low in reset", 32'(ready_o), 32'd0);
    check("R1 err low in reset", 32'(err_o), 32'd0);
    rst_n = 1'b1;

    // R1: all registers zero after reset
    for (int i = 0; i < NUM_REGS; i++) begin
      xfer(1'b0, 12'(4*i), 32'h0, 4'h0, 3'd0, 3'd0, cyc, e, rd);
      check("R1 register zero after reset", rd, 32'd0);
    end
    go_idle();

    // Table: back-to-back transfers, select held high (R2, R5, R6, R8, R9)
    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v].wr, VEC[v].addr, VEC[v].wdata, VEC[v].strb, VEC[v].wt, VEC[v].wt,
           cyc, e, rd);
      check("R2/R5 access cycles equal wait+1", 32'(cyc), 32'(VEC[v].wt) + 32'd1);
      check("R6 error response", 32'(e), 32'(VEC[v].err));
      if (!VEC[v].wr) check("R9 R8 read data", rd, VEC[v].rdata);
      else            check("R9 rdata zero on write", rd, 32'd0);
    end
    go_idle();

    // R3: read with garbage write data and full strobes leaves register intact
    xfer(1'b0, 12'h004, 32'h0BADF00D, 4'hF, 3'd2, 3'd2, cyc, e, rd);
    xfer(1'b0, 12'h004, 32'h0, 4'h0, 3'd0, 3'd0, cyc, e, rd);
    check("R3 read does not write", rd, 32'h00A500A5);
    go_idle();

    // R7: zero wait after idle gives two-cycle transfer
    xfer(1'b1, 12'h00C, 32'h87654321, 4'hF, 3'd0, 3'd0, cyc, e, rd);
    check("R7 zero wait one access cycle", 32'(cyc), 32'd1);
    go_idle();

    // R10: count changed during access has no effect
    xfer(1'b0, 12'h00C, 32'h0, 4'h0, 3'd1, 3'd6, cyc, e, rd);
    check("R10 wait change ignored", 32'(cyc), 32'd2);
    check("R10 read after full write", rd, 32'h87654321);
    xfer(1'b0, 12'h00C, 32'h0, 4'h0, 3'd6, 3'd0, cyc, e, rd);
    check("R10 R2 larger setup count kept", 32'(cyc), 32'd7);
    go_idle();

    // R6: unmapped write changed none of the registers
    xfer(1'b0, 12'h008, 32'h0, 4'h0, 3'd0, 3'd0, cyc, e, rd);
    check("R6 register 2 untouched by unmapped write", rd, 32'hDE00BE00);
    go_idle();

    // R1: reset in mid-run clears contents
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    xfer(1'b0, 12'h000, 32'h0, 4'h0, 3'd0, 3'd0, cyc, e, rd);
    check("R1 register zero after second reset", rd, 32'd0);
    check("R1 R7 counter idle after reset", 32'(cyc), 32'd1);
    go_idle();

    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule